// File: doc/BRIEF.md
# Capability Pointer Comparison Unit

This block compares two capability operands and produces a single truth bit, zero-extended to the full register width, for a general-purpose destination register. Each operand is presented as a decoded record: a validity tag, a sealed flag, a base, an offset and a bundle of remaining fields. For every operand the unit derives a cursor, which is the base plus the offset, wrapped to the register width. It then applies one of eight comparisons chosen by a 3-bit operation code. Six of the comparisons act on the cursors: equality, inequality, and less-than and less-or-equal in both signed and unsigned form. The remaining two compare the complete records for exact identity.

The unit also guards a window of protected system capability register numbers. A source operand can name a register inside that window while the program-counter capability lacks the right to reach system registers. In that case the unit raises an access violation and reports which register number caused it, and it writes nothing. The comparison logic is combinational. A small sequencer registers the outcome, so the write strobe or the violation pulse appears one cycle after an accepted request.

The sequencer has three states. ST_IDLE means no request. ST_WRITE means a result is being written this cycle. ST_FAULT means a violation is being reported this cycle. The state moves as follows. A request that passes the guard goes to ST_WRITE. A request that fails the guard goes to ST_FAULT. With no request the state is ST_IDLE. The next state is chosen the same way from every state, so each of ST_WRITE and ST_FAULT lasts exactly one cycle unless another request arrives.

Top module: `cap_ptr_cmp`

## Requirements
- R1: After reset, wr_en and viol are 0 and wr_data is all zeros.
- R2: Each operand's cursor is base + offset modulo 2^XLEN, so two operands whose sums are equal after wraparound compare as equal even when their bases and offsets differ.
- R3: Operation code 000 yields 1 when the cursors are equal, and code 001 yields 1 when they differ.
- R4: Code 010 yields 1 when cursor A is less than cursor B taken as two's-complement values. Code 011 yields that result ORed with cursor equality.
- R5: Code 100 yields 1 when cursor A is less than cursor B taken as unsigned values. Code 101 yields that result ORed with cursor equality.
- R6: Code 110 yields 1 only when tag, sealed flag, base, offset and remaining fields all match between A and B. Code 111 yields the inverse.
- R7: wr_data carries the result in bit 0, and bits XLEN-1 down to 1 are always 0.
- R8: A request with in_valid high that raises no violation produces wr_en high for exactly one cycle, on the cycle after the request, with wr_idx equal to the requested destination. A cycle without in_valid produces neither wr_en nor viol on the next cycle.
- R9: When pcc_sys_ok is 0 and either source number lies in the protected window (27 to 29 by default), the cycle after the request has viol high and wr_en low. viol_idx then holds the offending number, and operand A's number is reported when both operands are protected.
- R10: When pcc_sys_ok is 1, protected source numbers raise no violation and the result is written normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op_sel | input | 3 | Comparison code (see R3 to R6) |
| src_a_idx | input | 5 | Register number of operand A |
| src_b_idx | input | 5 | Register number of operand B |
| dst_idx | input | 5 | Destination general register number |
| pcc_sys_ok | input | 1 | Program-counter capability grants system-register access |
| a_tag | input | 1 | Operand A validity tag |
| a_sealed | input | 1 | Operand A sealed flag |
| a_base | input | 64 | Operand A base |
| a_offset | input | 64 | Operand A offset |
| a_rest | input | 32 | Operand A remaining fields |
| b_tag | input | 1 | Operand B validity tag |
| b_sealed | input | 1 | Operand B sealed flag |
| b_base | input | 64 | Operand B base |
| b_offset | input | 64 | Operand B offset |
| b_rest | input | 32 | Operand B remaining fields |
| wr_en | output | 1 | Destination write strobe |
| wr_idx | output | 5 | Destination register number |
| wr_data | output | 64 | Zero-extended comparison result |
| viol | output | 1 | System-register access violation |
| viol_idx | output | 5 | Register number that caused the violation |

## Verification
The bench builds the unit with its defaults: XLEN of 64, 32 bits of remaining fields and a protected window of 27 to 29. At 64 bits the bench can reach the exact wrap of base plus offset past 2^64 and the sign boundary at bit 63. The sign boundary is where signed and unsigned ordering disagree. The three-entry window lets the bench test a single protected operand on either side, both operands protected so that A's priority shows, and the system-access override.

// File: rtl/cap_cmp_pkg.sv
package cap_cmp_pkg;
    typedef enum logic [2:0] {
        OP_EQ  = 3'd0,
        OP_NE  = 3'd1,
        OP_SLT = 3'd2,
        OP_SLE = 3'd3,
        OP_ULT = 3'd4,
        OP_ULE = 3'd5,
        OP_XEQ = 3'd6,
        OP_XNE = 3'd7
    } cmp_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_FAULT = 2'd2
    } seq_st_e;
endpackage

// File: rtl/cap_cursor.sv
module cap_cursor #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] offset,
    output logic [XLEN-1:0] cursor
);
    // Carry out of the top bit is dropped: wrap modulo 2^XLEN.
    assign cursor = base + offset;
endmodule

// File: rtl/cap_sysreg_guard.sv
module cap_sysreg_guard #(
    parameter int IDXW      = 5,
    parameter int SYS_FIRST = 27,
    parameter int SYS_LAST  = 29
) (
    input  logic [IDXW-1:0] idx_a,
    input  logic [IDXW-1:0] idx_b,
    input  logic            sys_ok,
    output logic            hit,
    output logic [IDXW-1:0] culprit
);
    localparam logic [IDXW-1:0] LO = IDXW'(SYS_FIRST);
    localparam logic [IDXW-1:0] HI = IDXW'(SYS_LAST);

    logic prot_a, prot_b;

    assign prot_a  = (idx_a >= LO) && (idx_a <= HI);
    assign prot_b  = (idx_b >= LO) && (idx_b <= HI);
    assign hit     = !sys_ok && (prot_a || prot_b);
    // Operand A is examined first and wins when both are protected.
    assign culprit = prot_a ? idx_a : idx_b;
endmodule

// File: rtl/cap_cmp_core.sv
module cap_cmp_core
    import cap_cmp_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int RECW = 162
) (
    input  cmp_op_e         op,
    input  logic [XLEN-1:0] cur_a,
    input  logic [XLEN-1:0] cur_b,
    input  logic [RECW-1:0] rec_a,
    input  logic [RECW-1:0] rec_b,
    output logic            res,
    output logic            c_eq,
    output logic            s_lt,
    output logic            u_lt
);
    logic same_rec;

    assign c_eq     = (cur_a == cur_b);
    assign s_lt     = $signed(cur_a) < $signed(cur_b);
    assign u_lt     = cur_a < cur_b;
    assign same_rec = (rec_a == rec_b);

    always_comb begin
        unique case (op)
            OP_EQ:   res = c_eq;
            OP_NE:   res = !c_eq;
            OP_SLT:  res = s_lt;
            OP_SLE:  res = s_lt | c_eq;
            OP_ULT:  res = u_lt;
            OP_ULE:  res = u_lt | c_eq;
            OP_XEQ:  res = same_rec;
            OP_XNE:  res = !same_rec;
            default: res = 1'b0;
        endcase
    end
endmodule

// File: rtl/cap_ptr_cmp.sv
module cap_ptr_cmp
    import cap_cmp_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int RESTW     = 32,
    parameter int IDXW      = 5,
    parameter int SYS_FIRST = 27,
    parameter int SYS_LAST  = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       op_sel,
    input  logic [IDXW-1:0]  src_a_idx,
    input  logic [IDXW-1:0]  src_b_idx,
    input  logic [IDXW-1:0]  dst_idx,
    input  logic             pcc_sys_ok,
    input  logic             a_tag,
    input  logic             a_sealed,
    input  logic [XLEN-1:0]  a_base,
    input  logic [XLEN-1:0]  a_offset,
    input  logic [RESTW-1:0] a_rest,
    input  logic             b_tag,
    input  logic             b_sealed,
    input  logic [XLEN-1:0]  b_base,
    input  logic [XLEN-1:0]  b_offset,
    input  logic [RESTW-1:0] b_rest,
    output logic             wr_en,
    output logic [IDXW-1:0]  wr_idx,
    output logic [XLEN-1:0]  wr_data,
    output logic             viol,
    output logic [IDXW-1:0]  viol_idx
);
    localparam int RECW = 2 + 2 * XLEN + RESTW;

    logic [XLEN-1:0] cur_a, cur_b;
    logic [RECW-1:0] rec_a, rec_b;
    logic            res, c_eq, s_lt, u_lt;
    logic            guard_hit;
    logic [IDXW-1:0] culprit;

    seq_st_e         state_q, state_d;
    logic            res_q;
    logic [IDXW-1:0] dst_q, bad_q;

    assign rec_a = {a_tag, a_sealed, a_base, a_offset, a_rest};
    assign rec_b = {b_tag, b_sealed, b_base, b_offset, b_rest};

    cap_cursor #(.XLEN(XLEN)) u_cur_a (.base(a_base), .offset(a_offset), .cursor(cur_a));
    cap_cursor #(.XLEN(XLEN)) u_cur_b (.base(b_base), .offset(b_offset), .cursor(cur_b));

    cap_cmp_core #(.XLEN(XLEN), .RECW(RECW)) u_core (
        .op(cmp_op_e'(op_sel)), .cur_a(cur_a), .cur_b(cur_b),
        .rec_a(rec_a), .rec_b(rec_b),
        .res(res), .c_eq(c_eq), .s_lt(s_lt), .u_lt(u_lt)
    );

    cap_sysreg_guard #(.IDXW(IDXW), .SYS_FIRST(SYS_FIRST), .SYS_LAST(SYS_LAST)) u_guard (
        .idx_a(src_a_idx), .idx_b(src_b_idx), .sys_ok(pcc_sys_ok),
        .hit(guard_hit), .culprit(culprit)
    );

    // Next state: identical from every state, each request lasts one cycle.
    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_WRITE, ST_FAULT: begin
                if (!in_valid)      state_d = ST_IDLE;
                else if (guard_hit) state_d = ST_FAULT;
                else                state_d = ST_WRITE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output payload registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= 1'b0;
            dst_q <= '0;
            bad_q <= '0;
        end else if (in_valid) begin
            res_q <= res;
            dst_q <= dst_idx;
            bad_q <= culprit;
        end
    end

    assign wr_en    = (state_q == ST_WRITE);
    assign viol     = (state_q == ST_FAULT);
    assign wr_idx   = dst_q;
    assign viol_idx = bad_q;
    assign wr_data  = {{(XLEN-1){1'b0}}, res_q};

    // R8: accepted, unguarded request yields a write next cycle
    a_r8_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !guard_hit) |=> (wr_en && !viol && wr_idx == $past(dst_idx)));
    // R8: no request, no strobe
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!wr_en && !viol));
    // R9: guarded request faults and suppresses the write
    a_r9_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && guard_hit) |=> (viol && !wr_en));
    // R10: system access granted means no violation
    a_r10_override: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pcc_sys_ok) |=> !viol);
    // R4: signed less-than and cursor equality are exclusive
    a_r4_order: assert property (@(posedge clk) disable iff (!rst_n)
        !(c_eq && s_lt));
    // R5: unsigned less-than and cursor equality are exclusive
    a_r5_order: assert property (@(posedge clk) disable iff (!rst_n)
        !(c_eq && u_lt));
    // R7: upper result bits stay clear while writing
    a_r7_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data[XLEN-1:1] == '0));
endmodule

// File: tb/tb_cap_ptr_cmp.sv
`timescale 1ns/1ps
module tb_cap_ptr_cmp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [4:0]  src_a_idx = 5'd1, src_b_idx = 5'd2, dst_idx = 5'd3;
    logic        pcc_sys_ok = 1'b0;
    logic        a_tag = 1'b1, a_sealed = 1'b0, b_tag = 1'b1, b_sealed = 1'b0;
    logic [63:0] a_base = '0, a_offset = '0, b_base = '0, b_offset = '0;
    logic [31:0] a_rest = '0, b_rest = '0;
    logic        wr_en, viol;
    logic [4:0]  wr_idx, viol_idx;
    logic [63:0] wr_data;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    cap_ptr_cmp dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .dst_idx(dst_idx),
        .pcc_sys_ok(pcc_sys_ok),
        .a_tag(a_tag), .a_sealed(a_sealed), .a_base(a_base), .a_offset(a_offset), .a_rest(a_rest),
        .b_tag(b_tag), .b_sealed(b_sealed), .b_base(b_base), .b_offset(b_offset), .b_rest(b_rest),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .viol(viol), .viol_idx(viol_idx)
    );

    localparam int NV = 14;
    localparam logic [63:0] SGN = 64'h8000_0000_0000_0000;
    localparam logic [2:0]  V_OP  [NV] = '{3'd0, 3'd0, 3'd1, 3'd2, 3'd2, 3'd3, 3'd3,
                                           3'd4, 3'd4, 3'd5, 3'd5, 3'd6, 3'd6, 3'd7};
    localparam logic [63:0] V_AB  [NV] = '{64'd100, 64'hFFFF_FFFF_FFFF_FFF0, 64'd100, SGN, 64'd1,
                                           64'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, SGN, 64'd9,
                                           64'd3, 64'd40, 64'd40, 64'd40};
    localparam logic [63:0] V_AO  [NV] = '{64'd20, 64'h20, 64'd20, 64'd0, 64'd0, 64'd0, 64'd0,
                                           64'd0, 64'd0, 64'd0, 64'd0, 64'd2, 64'd2, 64'd2};
    localparam logic [63:0] V_BB  [NV] = '{64'd60, 64'd8, 64'd60, 64'd1, SGN,
                                           64'd5, 64'hFFFF_FFFF_FFFF_FFFE, SGN, 64'd1, 64'd9,
                                           64'd2, 64'd40, 64'd41, 64'd41};
    localparam logic [63:0] V_BO  [NV] = '{64'd60, 64'd8, 64'd60, 64'd0, 64'd0, 64'd0, 64'd0,
                                           64'd0, 64'd0, 64'd0, 64'd0, 64'd2, 64'd1, 64'd1};
    localparam logic        V_EXP [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
                                           1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one request at a falling edge, then sample just after the capturing edge.
    task automatic issue();
        @(negedge clk);
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_write(input string req, input logic exp_bit);
        chk(wr_en === 1'b1 && viol === 1'b0, req, {62'd0, viol, wr_en}, 64'd1);
        chk(wr_data === {63'd0, exp_bit}, req, wr_data, {63'd0, exp_bit});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(wr_en === 1'b0 && viol === 1'b0, "R1", {62'd0, viol, wr_en}, 64'd0);
        chk(wr_data === 64'd0, "R1", wr_data, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R2 wrap/sums, R3, R4, R5, R6, R7
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_sel = V_OP[i];
            a_base = V_AB[i]; a_offset = V_AO[i];
            b_base = V_BB[i]; b_offset = V_BO[i];
            dst_idx = 5'(i + 4);
            in_valid = 1'b1;
            @(posedge clk);
            #1;
            chk(wr_en === 1'b1, "R8", {63'd0, wr_en}, 64'd1);
            chk(wr_idx === 5'(i + 4), "R8", {59'd0, wr_idx}, 64'(i + 4));
            chk(wr_data === {63'd0, V_EXP[i]}, "R2-table R3/R4/R5/R6/R7",
                wr_data, {63'd0, V_EXP[i]});
        end
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        // R8: strobe lasts one cycle, idle gives nothing
        chk(wr_en === 1'b0 && viol === 1'b0, "R8", {62'd0, viol, wr_en}, 64'd0);

        // R6: tag difference breaks exact equality though cursors match
        a_base = 64'd7; a_offset = 64'd0; b_base = 64'd7; b_offset = 64'd0;
        b_tag = 1'b0; op_sel = 3'd6;
        issue();
        expect_write("R6", 1'b0);
        op_sel = 3'd0;
        issue();
        expect_write("R3", 1'b1);
        b_tag = 1'b1;
        // R6: remaining-field difference makes exact-not-equal true
        b_rest = 32'h1; op_sel = 3'd7;
        issue();
        expect_write("R6", 1'b1);
        b_rest = 32'h0; b_sealed = 1'b1; op_sel = 3'd6;
        issue();
        expect_write("R6", 1'b0);
        b_sealed = 1'b0;

        // R9: protected A
        op_sel = 3'd0; src_a_idx = 5'd27; src_b_idx = 5'd2;
        issue();
        chk(viol === 1'b1 && wr_en === 1'b0, "R9", {62'd0, viol, wr_en}, 64'd2);
        chk(viol_idx === 5'd27, "R9", {59'd0, viol_idx}, 64'd27);
        // R9: protected B only
        src_a_idx = 5'd26; src_b_idx = 5'd29;
        issue();
        chk(viol === 1'b1 && wr_en === 1'b0, "R9", {62'd0, viol, wr_en}, 64'd2);
        chk(viol_idx === 5'd29, "R9", {59'd0, viol_idx}, 64'd29);
        // R9: both protected, A reported
        src_a_idx = 5'd28; src_b_idx = 5'd29;
        issue();
        chk(viol_idx === 5'd28, "R9", {59'd0, viol_idx}, 64'd28);
        // R9: just outside window is allowed
        src_a_idx = 5'd30; src_b_idx = 5'd26;
        issue();
        expect_write("R9", 1'b1);
        // R10: override
        src_a_idx = 5'd27; src_b_idx = 5'd28; pcc_sys_ok = 1'b1;
        issue();
        expect_write("R10", 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule